// File: doc/BRIEF.md
# Watchdog Reset Gate with Cause Capture

This block sits between a set of watchdog clusters and the chip-level reset controller, in an always-on domain that only power-on reset clears. Each watchdog cluster raises a reset request. The block lets that request through to a single system reset output only when software has allowed it, and only when the processor served by that cluster is not already held in reset (if automatic suppression is enabled for that cluster). A per-cluster counter-enable bit is driven out to start or stop the attached watchdog counter.

Whenever a request gets through, the system reset output is asserted and held for at least 16 cycles. The block records which clusters caused the reset in a cause register. Because the block is not cleared by the reset it produces, software can read the cause after the reset is over. The per-cluster gating bit has a build-time polarity. With the direct polarity, a 1 blocks the request. With the inverted polarity, a 1 lets the request through. At power-on, every cluster is blocked in either polarity.

Software uses a small register port with four word addresses. In each register, bit c belongs to cluster c.

Top module: `wdt_reset_gate`

## Requirements
- R1: After power-on reset `rst`, the gate register (address 0) reads bit c = 1 for a direct-polarity cluster and 0 for an inverted-polarity cluster, so every request is blocked. The counter-enable (address 1), auto-suppress (address 2) and cause (address 3) registers read 0. `sys_rst` and `wdt_cnt_en` are 0.
- R2: A write with `cfg_wr` high stores `cfg_wdata` into the addressed register at the clock edge. `cfg_rdata` returns the register at `cfg_addr` one clock after the address is presented. Bit c of each register belongs to cluster c.
- R3: For a cluster with MASK_INV bit c = 0, gate bit c = 1 blocks that cluster's request and gate bit c = 0 lets it through.
- R4: For a cluster with MASK_INV bit c = 1, gate bit c = 1 lets that cluster's request through and gate bit c = 0 blocks it.
- R5: When auto-suppress bit c is 1 and `cpu_held[c]` is 1, the request of cluster c is ignored: no reset and no cause bit. With auto-suppress bit c = 0, `cpu_held[c]` has no effect.
- R6: `wdt_cnt_en` equals the counter-enable register. It changes on the clock edge that takes the write.
- R7: A request that gets through and is sampled at edge k drives `sys_rst` high from edge k until 16 cycles after the last such sampled request. A single-cycle request gives exactly 16 cycles.
- R8: `sys_rst` is the OR over all clusters of the requests that get through. Requests from different clusters during one asserted reset extend the same pulse.
- R9: When a request gets through while `sys_rst` is low, the cause register is replaced by the set of clusters whose requests get through in that cycle. While `sys_rst` is high, further clusters that get through are ORed into the cause register.
- R10: The cause register keeps its value through and after the reset it caused. A write to address 3 clears the bits written as 1 and leaves the others unchanged. A cluster that gets through in the same cycle as the clear keeps its bit set. Power-on reset clears the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word address (0 gate, 1 counter enable, 2 auto-suppress, 3 cause) |
| cfg_wdata | input | NUM_CL | Write data, one bit per cluster |
| cfg_rdata | output | NUM_CL | Registered read data for `cfg_addr` |
| wdt_rst_req | input | NUM_CL | Watchdog reset request per cluster |
| cpu_held | input | NUM_CL | Processor of the cluster is currently in reset |
| wdt_cnt_en | output | NUM_CL | Counter-enable per cluster |
| sys_rst | output | 1 | Stretched system reset request |

## Verification
The bench targets these corner cases:

- **Polarity.** Each polarity is driven with its gate bit in both states. A design with the polarity swapped would either let a request through under power-on defaults or block the configured one.
- **Auto-suppress.** Suppression is tested with the processor held and released, and on a cluster whose suppress bit is clear. A design that ignored the held input, or applied it without the enable bit, would produce an unexpected pulse or miss one.
- **Pulse length.** The scoreboard compares each pulse length with the expected value: 16 for a single request, and longer for held or overlapping requests from two clusters. An off-by-one reload or a counter that restarts on the wrong edge shows up as a wrong length.
- **Cause register.** The bench checks replacement at the start of a new event, OR-in during an active event, selective write-one-to-clear, set winning over a clear in the same cycle, and clearing at power-on. A design that only ORs, or lets the clear win, reads back the wrong bits.

// File: rtl/wrg_pkg.sv
package wrg_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_GATE    = 2'd0,
    REG_CNTEN   = 2'd1,
    REG_AUTODIS = 2'd2,
    REG_CAUSE   = 2'd3
  } wrg_reg_e;
endpackage

// File: rtl/wrg_cfg_regs.sv
module wrg_cfg_regs
  import wrg_pkg::*;
#(
  parameter int              NUM_CL   = 2,
  parameter logic [NUM_CL-1:0] MASK_INV = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NUM_CL-1:0] wr_data,
  output logic [NUM_CL-1:0] gate_q,
  output logic [NUM_CL-1:0] cnten_q,
  output logic [NUM_CL-1:0] autodis_q
);
  // Power-on value blocks every cluster in its own polarity
  localparam logic [NUM_CL-1:0] GATE_RST = ~MASK_INV;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q    <= GATE_RST;
      cnten_q   <= '0;
      autodis_q <= '0;
    end else if (wr_en) begin
      case (wrg_reg_e'(wr_addr))
        REG_GATE:    gate_q    <= wr_data;
        REG_CNTEN:   cnten_q   <= wr_data;
        REG_AUTODIS: autodis_q <= wr_data;
        default: ;
      endcase
    end
  end

  // R1: configuration returns to its blocked, stopped state after power-on
  p_cfg_por_r1: assert property (@(posedge clk)
    rst |=> (cnten_q == '0 && autodis_q == '0 && gate_q == GATE_RST));
endmodule

// File: rtl/wrg_gate.sv
module wrg_gate #(
  parameter int                NUM_CL   = 2,
  parameter logic [NUM_CL-1:0] MASK_INV = '0
) (
  input  logic [NUM_CL-1:0] req,
  input  logic [NUM_CL-1:0] gate,
  input  logic [NUM_CL-1:0] autodis,
  input  logic [NUM_CL-1:0] held,
  output logic [NUM_CL-1:0] pass
);
  logic [NUM_CL-1:0] blocked;

  for (genvar c = 0; c < NUM_CL; c++) begin : g_cl
    if (MASK_INV[c]) begin : g_inv
      assign blocked[c] = ~gate[c];
    end else begin : g_dir
      assign blocked[c] = gate[c];
    end
  end

  assign pass = req & ~blocked & ~(autodis & held);
endmodule

// File: rtl/wrg_stretch.sv
module wrg_stretch #(
  parameter int STRETCH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic active
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (trig)          cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);

  // Checker: length of the current high run, saturating
  logic [CW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)                        run_q <= '0;
    else if (!active)               run_q <= '0;
    else if (run_q != LOAD)         run_q <= run_q + 1'b1;
  end

  // R7: a request reaches the output on the next cycle
  p_rise_after_trig_r7: assert property (@(posedge clk) disable iff (rst)
    trig |=> active);
  // R7: no pulse shorter than the minimum width
  p_min_width_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> (run_q == LOAD));
endmodule

// File: rtl/wrg_cause.sv
module wrg_cause #(
  parameter int NUM_CL = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CL-1:0] pass,
  input  logic              in_event,
  input  logic              clr_en,
  input  logic [NUM_CL-1:0] clr_bits,
  output logic [NUM_CL-1:0] cause_q
);
  logic [NUM_CL-1:0] kept;

  assign kept = clr_en ? (cause_q & ~clr_bits) : cause_q;

  always_ff @(posedge clk) begin
    if (rst)                        cause_q <= '0;
    else if (!in_event && |pass)    cause_q <= pass;
    else                            cause_q <= kept | pass;
  end

  // R9: every cluster that gets through is recorded
  p_cause_set_r9: assert property (@(posedge clk) disable iff (rst)
    (|pass) |=> ((cause_q & $past(pass)) == $past(pass)));
  // R10: without a clear or a new request the cause is held
  p_cause_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!clr_en && pass == '0) |=> $stable(cause_q));
endmodule

// File: rtl/wdt_reset_gate.sv
module wdt_reset_gate
  import wrg_pkg::*;
#(
  parameter int                NUM_CL   = 2,
  parameter logic [NUM_CL-1:0] MASK_INV = 2'b10,
  parameter int                STRETCH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [NUM_CL-1:0] cfg_wdata,
  output logic [NUM_CL-1:0] cfg_rdata,
  input  logic [NUM_CL-1:0] wdt_rst_req,
  input  logic [NUM_CL-1:0] cpu_held,
  output logic [NUM_CL-1:0] wdt_cnt_en,
  output logic              sys_rst
);
  logic [NUM_CL-1:0] gate_w, cnten_w, autodis_w, pass_w, cause_w;
  logic              clr_en;

  wrg_cfg_regs #(.NUM_CL(NUM_CL), .MASK_INV(MASK_INV)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_wr),
    .wr_addr   (cfg_addr),
    .wr_data   (cfg_wdata),
    .gate_q    (gate_w),
    .cnten_q   (cnten_w),
    .autodis_q (autodis_w)
  );

  wrg_gate #(.NUM_CL(NUM_CL), .MASK_INV(MASK_INV)) u_gate (
    .req     (wdt_rst_req),
    .gate    (gate_w),
    .autodis (autodis_w),
    .held    (cpu_held),
    .pass    (pass_w)
  );

  wrg_stretch #(.STRETCH(STRETCH)) u_stretch (
    .clk    (clk),
    .rst    (rst),
    .trig   (|pass_w),
    .active (sys_rst)
  );

  assign clr_en = cfg_wr && (wrg_reg_e'(cfg_addr) == REG_CAUSE);

  wrg_cause #(.NUM_CL(NUM_CL)) u_cause (
    .clk      (clk),
    .rst      (rst),
    .pass     (pass_w),
    .in_event (sys_rst),
    .clr_en   (clr_en),
    .clr_bits (cfg_wdata),
    .cause_q  (cause_w)
  );

  assign wdt_cnt_en = cnten_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      case (wrg_reg_e'(cfg_addr))
        REG_GATE:    cfg_rdata <= gate_w;
        REG_CNTEN:   cfg_rdata <= cnten_w;
        REG_AUTODIS: cfg_rdata <= autodis_w;
        default:     cfg_rdata <= cause_w;
      endcase
    end
  end

  // R8: the system reset only rises because some cluster got through
  p_rise_has_source_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst) |-> $past(|pass_w));
  // R6: counter enable output tracks its register write
  p_cnten_follow_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && wrg_reg_e'(cfg_addr) == REG_CNTEN) |=> (wdt_cnt_en == $past(cfg_wdata)));
endmodule

// File: tb/wdt_reset_gate_test.sv
module wdt_reset_gate_test;
  localparam int NCL = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cfg_wr = 1'b0;
  logic [1:0]     cfg_addr = '0;
  logic [NCL-1:0] cfg_wdata = '0;
  logic [NCL-1:0] cfg_rdata;
  logic [NCL-1:0] wdt_rst_req = '0;
  logic [NCL-1:0] cpu_held = '0;
  logic [NCL-1:0] wdt_cnt_en;
  logic           sys_rst;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  wdt_reset_gate #(.NUM_CL(NCL), .MASK_INV(2'b10), .STRETCH(16)) uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wdt_rst_req(wdt_rst_req),
    .cpu_held(cpu_held), .wdt_cnt_en(wdt_cnt_en), .sys_rst(sys_rst)
  );

  always #5 clk = ~clk;

  // scoreboard queues
  int    rd_exp_q[$];
  string rd_tag_q[$];
  int    pl_exp_q[$];
  string pl_tag_q[$];
  logic  rd_issue = 1'b0;
  logic  rd_stage = 1'b0;
  int    run = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // read monitor
  always @(posedge clk) rd_stage <= rd_issue;
  always @(negedge clk) begin
    if (rd_stage) begin
      if (rd_exp_q.size() == 0) check("R2 unexpected read", 1, 0);
      else check(rd_tag_q.pop_front(), int'(cfg_rdata), rd_exp_q.pop_front());
    end
  end

  // pulse monitor
  always @(negedge clk) begin
    if (rst) run = 0;
    else if (sys_rst) run++;
    else if (run > 0) begin
      if (pl_exp_q.size() == 0) check("R3/R4/R5 unexpected reset pulse", run, 0);
      else check(pl_tag_q.pop_front(), run, pl_exp_q.pop_front());
      run = 0;
    end
  end

  task automatic wr(int a, int d);
    cfg_addr = 2'(a); cfg_wdata = NCL'(d); cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(int a, int e, string tag);
    cfg_addr = 2'(a); rd_issue = 1'b1;
    rd_exp_q.push_back(e); rd_tag_q.push_back(tag);
    @(negedge clk);
    rd_issue = 1'b0;
  endtask

  task automatic pulse(int m, int h, bit expect_pulse, string tag);
    if (expect_pulse) begin
      pl_exp_q.push_back(h + 15); pl_tag_q.push_back(tag);
    end
    for (int i = 0; i < h; i++) begin
      wdt_rst_req = NCL'(m);
      @(negedge clk);
    end
    wdt_rst_req = '0;
    repeat (24) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    check("R1 sys_rst after power-on", int'(sys_rst), 0);
    check("R1 cnt_en after power-on", int'(wdt_cnt_en), 0);
    rd(0, 1, "R1 gate reset value");
    rd(1, 0, "R1 cnt_en reset value");
    rd(2, 0, "R1 autodis reset value");
    rd(3, 0, "R1 cause reset value");
    pulse(3, 2, 0, "R1 blocked at power-on");
    rd(3, 0, "R1 no cause while blocked");

    // counter enable
    wr(1, 2);
    check("R6 cnt_en after write 10", int'(wdt_cnt_en), 2);
    rd(1, 2, "R2 cnt_en readback");
    wr(1, 1);
    check("R6 cnt_en after write 01", int'(wdt_cnt_en), 1);

    // direct polarity cluster 0
    wr(0, 0);
    rd(0, 0, "R2 gate readback");
    pulse(1, 1, 1, "R3 R7 single-cycle pulse width");
    rd(3, 1, "R9 cause after cluster0");
    pulse(2, 3, 0, "R4 inverted cluster blocked by 0");
    rd(3, 1, "R4 cause unchanged when blocked");

    // inverted polarity cluster 1
    wr(0, 3);
    pulse(1, 2, 0, "R3 direct cluster blocked by 1");
    pulse(2, 3, 1, "R4 R7 held request width");
    rd(3, 2, "R9 cause replaced by new event");

    // both clusters within one event
    wr(0, 2);
    pl_exp_q.push_back(21); pl_tag_q.push_back("R8 overlapping clusters extend pulse");
    wdt_rst_req = 2'b01; repeat (2) @(negedge clk);
    wdt_rst_req = 2'b00; repeat (3) @(negedge clk);
    wdt_rst_req = 2'b10; @(negedge clk);
    wdt_rst_req = 2'b00; repeat (24) @(negedge clk);
    rd(3, 3, "R9 cause ORed during event");
    pulse(3, 1, 1, "R8 simultaneous clusters");
    rd(3, 3, "R9 both clusters in cause");

    // write-one-to-clear
    wr(3, 1);
    rd(3, 2, "R10 clear bit0 only");
    wr(3, 0);
    rd(3, 2, "R10 write zero keeps cause");
    wr(3, 2);
    rd(3, 0, "R10 clear bit1");

    // set wins over clear
    pl_exp_q.push_back(16); pl_tag_q.push_back("R7 pulse with concurrent clear");
    wdt_rst_req = 2'b01; cfg_addr = 2'd3; cfg_wdata = 2'b01; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; wdt_rst_req = '0;
    repeat (24) @(negedge clk);
    rd(3, 1, "R10 set wins over clear");

    // auto-suppress
    wr(3, 3);
    wr(2, 1);
    rd(2, 1, "R2 autodis readback");
    cpu_held = 2'b01;
    pulse(1, 2, 0, "R5 suppressed while cpu held");
    rd(3, 0, "R5 no cause while suppressed");
    cpu_held = 2'b00;
    pulse(1, 1, 1, "R5 passes when cpu released");
    rd(3, 1, "R5 cause after release");
    cpu_held = 2'b10;
    pulse(2, 1, 1, "R5 held ignored without autodis");
    rd(3, 2, "R5 cause cluster1 with held");
    cpu_held = 2'b00;

    // power-on reset clears everything
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 cnt_en after second power-on", int'(wdt_cnt_en), 0);
    rd(3, 0, "R10 power-on clears cause");
    rd(0, 1, "R1 gate restored");

    repeat (4) @(negedge clk);
    check("R7 all expected pulses seen", pl_exp_q.size(), 0);
    check("R2 all reads answered", rd_exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule